// File: doc/BRIEF.md
# Timer Interrupt Routing Controller

This block holds the per-timer interrupt configuration of a multi-timer event unit and turns each timer's fire strobe into an interrupt. A fire becomes one of three things, chosen by the timer's configuration word: a single-cycle pulse on one line of a 32-line interrupt-controller pin vector, a level held on that line until software acknowledges it, or a message write made of a 32-bit address and a 32-bit data word taken from the timer's message register. The counter and comparator that produce the fire strobes sit outside this block.

Each timer has a 64-bit configuration word whose upper half is a read-only mask of the pins it may drive. Writes keep every read-only field, silently reset an illegal route to "unrouted" (pin 0), and drop a pending level interrupt whenever the new configuration would leave it stranded. A per-timer status bit records a held level interrupt. Software clears it with a write-one-to-clear strobe, and a fire is ignored while it is set.

Top module: `tirc_top`

## Requirements
- R1: After reset every configuration word reads {allowed-pin mask, 16'h0000, 16'h8010}: the message-capable bit 15 and the periodic-capable bit 4 are 1. The mask is 0xFF000000 for PIN_COUNT >= 32, 0xF << (PIN_COUNT-4) for PIN_COUNT >= 20 and 0 otherwise (0x00F00000 at the default 24). Message registers, status bits, pin_pulse, pin_level and msg_valid are all 0.
- R2: A configuration write keeps bits 63:32, 15, 5 and 4 at their old values, always clears bit 8, and takes every other bit from the written data.
- R3: The route is bits 13:9, a 5-bit pin number. Outside message mode, a write that selects a non-zero pin whose allowed-mask bit is 0 leaves the route at 0. In message mode the route field is stored unchecked.
- R4: A fire does nothing when the enable bit 2 is 0, or when the timer is in pin mode with route 0.
- R5: With bit 1 = 0 (edge type), an accepted fire sets pin_pulse[route] for exactly the one cycle after the fire.
- R6: With bit 1 = 1 (level type), an accepted fire sets the timer's status bit and holds pin_level[route] high. Further fires while the status bit is set produce no output.
- R7: Message mode is active only when bit 14 (enable) and bit 15 (capable) are both 1. An accepted fire then raises msg_valid for one cycle, with msg_addr = message register bits 63:32 and msg_data = bits 31:0, and drives no pin.
- R8: A 1 in stat_clr clears that timer's status bit and releases its level.
- R9: While the status bit is set, a configuration write that clears the enable bit, selects edge type, enters message mode or changes the effective pin clears the status bit. Any other write leaves it set.
- R10: When several timers request a message in the same cycle, the lowest-numbered timer is delivered and the others are dropped.
- R11: pin_level is the OR over all timers holding a level, so a shared pin stays high until every timer on it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDXW | Timer addressed by the configuration write |
| cfg_wdata | input | 64 | Configuration write data |
| msg_we | input | 1 | Message register write strobe |
| msg_idx | input | IDXW | Timer addressed by the message write |
| msg_wdata | input | 64 | Message register data: address in 63:32, data in 31:0 |
| stat_clr | input | NUM_TIMERS | Write-one-to-clear of the status bits |
| fire | input | NUM_TIMERS | Per-timer fire strobes |
| rd_idx | input | IDXW | Timer selected for readback |
| rd_cfg | output | 64 | Configuration word of the selected timer (0 if out of range) |
| rd_msg | output | 64 | Message register of the selected timer (0 if out of range) |
| status | output | NUM_TIMERS | Per-timer held-level status bits |
| pin_pulse | output | 32 | Single-cycle edge interrupts, one bit per pin |
| pin_level | output | 32 | Held level interrupts, one bit per pin |
| msg_valid | output | 1 | Message write strobe |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The assertions watch, on every cycle, that the read-only mask never moves on a write, that a stored route outside message mode is always an allowed pin, that a status bit survives until a clear or a configuration write, and that pulses and messages come only one cycle after a fire. Only the bench scenarios can show the exact values written back through the field merge, which pin or message each fire reaches, the OR of levels on a shared pin, and which configuration writes drop a pending level and which keep it.

// File: rtl/tirc_pkg.sv
package tirc_pkg;
  localparam int CFG_W      = 64;
  localparam int B_LVL      = 1;
  localparam int B_EN       = 2;
  localparam int B_PERCAP   = 4;
  localparam int B_SIZE     = 5;
  localparam int B_M32      = 8;
  localparam int B_ROUTE    = 9;
  localparam int ROUTE_W    = 5;
  localparam int B_MSGEN    = 14;
  localparam int B_MSGCAP   = 15;
  localparam int NPINS      = 32;

  localparam logic [CFG_W-1:0] RO_BITS =
    {32'hFFFF_FFFF, 16'h0000, 16'h8030};

  function automatic logic [31:0] allowed_mask(input int pins);
    if (pins >= 32)      return 32'hFF00_0000;
    else if (pins >= 20) return 32'h0000_000F << (pins - 4);
    else                 return 32'h0;
  endfunction
endpackage

// File: rtl/tirc_slice.sv
module tirc_slice
  import tirc_pkg::*;
#(
  parameter int PIN_COUNT = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic                msg_wr,
  input  logic [63:0]         msg_wdata,
  input  logic                fire_i,
  input  logic                clr_i,
  output logic [CFG_W-1:0]    cfg_q,
  output logic [63:0]         msg_q,
  output logic                status_q,
  output logic [ROUTE_W-1:0]  pin_o,
  output logic                edge_req,
  output logic                msg_req
);
  localparam logic [31:0] PMASK = allowed_mask(PIN_COUNT);
  localparam logic [CFG_W-1:0] CFG_RST = {PMASK, 16'h0000, 16'h8010};

  logic [CFG_W-1:0]   cfg_d, merged;
  logic [63:0]        msg_d;
  logic               status_d;
  logic               old_msg, new_msg, fire_ok, lvl_set, strand;
  logic [ROUTE_W-1:0] old_pin, cand_pin, new_pin;

  always_comb begin
    old_msg  = cfg_q[B_MSGCAP] & cfg_q[B_MSGEN];
    old_pin  = old_msg ? '0 : cfg_q[B_ROUTE +: ROUTE_W];
    fire_ok  = fire_i & cfg_q[B_EN] & ~status_q;
    edge_req = fire_ok & ~old_msg & (old_pin != '0) & ~cfg_q[B_LVL];
    lvl_set  = fire_ok & ~old_msg & (old_pin != '0) &  cfg_q[B_LVL];
    msg_req  = fire_ok & old_msg;
    pin_o    = old_pin;

    merged        = (cfg_wdata & ~RO_BITS) | (cfg_q & RO_BITS);
    merged[B_M32] = 1'b0;
    new_msg       = merged[B_MSGCAP] & merged[B_MSGEN];
    cand_pin      = new_msg ? '0 : merged[B_ROUTE +: ROUTE_W];
    new_pin       = cand_pin;
    if (cand_pin != '0 && !PMASK[cand_pin]) begin
      merged[B_ROUTE +: ROUTE_W] = '0;
      new_pin = '0;
    end
    strand = ~merged[B_EN] | new_msg | ~merged[B_LVL] | (new_pin != old_pin);

    cfg_d    = cfg_wr ? merged : cfg_q;
    msg_d    = msg_wr ? msg_wdata : msg_q;
    status_d = ((status_q & ~clr_i) | lvl_set) & ~(cfg_wr & strand);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= CFG_RST;
      msg_q    <= '0;
      status_q <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= cfg_d;
      if (msg_wr) msg_q <= msg_d;
      status_q <= status_d;
    end
  end

  // R2: the read-only pin mask never changes on a write
  a_r2_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cfg_q[63:32] == $past(cfg_q[63:32]));

  // R3: a stored route outside message mode is always an allowed pin
  a_r3_route_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (!old_msg && cfg_q[B_ROUTE +: ROUTE_W] != '0) |-> PMASK[cfg_q[B_ROUTE +: ROUTE_W]]);

  // R6: a held level stays until a clear or a configuration write
  a_r6_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !clr_i && !cfg_wr) |=> status_q);

  // R8: a clear strobe removes the held level
  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && clr_i) |=> !status_q);
endmodule

// File: rtl/tirc_msg_arb.sv
module tirc_msg_arb #(
  parameter int NUM_TIMERS = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_TIMERS-1:0]       req,
  input  logic [NUM_TIMERS-1:0][63:0] msgs,
  output logic                        valid_q,
  output logic [31:0]                 addr_q,
  output logic [31:0]                 data_q
);
  logic        valid_d;
  logic [63:0] pick;

  always_comb begin
    valid_d = 1'b0;
    pick    = '0;
    for (int i = NUM_TIMERS - 1; i >= 0; i--) begin
      if (req[i]) begin
        valid_d = 1'b1;
        pick    = msgs[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (valid_d) begin
        addr_q <= pick[63:32];
        data_q <= pick[31:0];
      end
    end
  end

  // R7: a message appears only in the cycle after a request
  a_r7_msg_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(|req));
endmodule

// File: rtl/tirc_top.sv
module tirc_top
  import tirc_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int PIN_COUNT  = 24,
  localparam int IDXW = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [IDXW-1:0]        cfg_idx,
  input  logic [63:0]            cfg_wdata,
  input  logic                   msg_we,
  input  logic [IDXW-1:0]        msg_idx,
  input  logic [63:0]            msg_wdata,
  input  logic [NUM_TIMERS-1:0]  stat_clr,
  input  logic [NUM_TIMERS-1:0]  fire,
  input  logic [IDXW-1:0]        rd_idx,
  output logic [63:0]            rd_cfg,
  output logic [63:0]            rd_msg,
  output logic [NUM_TIMERS-1:0]  status,
  output logic [31:0]            pin_pulse,
  output logic [31:0]            pin_level,
  output logic                   msg_valid,
  output logic [31:0]            msg_addr,
  output logic [31:0]            msg_data
);
  logic [NUM_TIMERS-1:0][63:0]        cfg_v, msg_v;
  logic [NUM_TIMERS-1:0][ROUTE_W-1:0] pin_v;
  logic [NUM_TIMERS-1:0]              edge_v, msgreq_v, stat_v;
  logic [31:0]                        pulse_d;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    tirc_slice #(.PIN_COUNT(PIN_COUNT)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_we && cfg_idx == IDXW'(i)),
      .cfg_wdata(cfg_wdata),
      .msg_wr   (msg_we && msg_idx == IDXW'(i)),
      .msg_wdata(msg_wdata),
      .fire_i   (fire[i]),
      .clr_i    (stat_clr[i]),
      .cfg_q    (cfg_v[i]),
      .msg_q    (msg_v[i]),
      .status_q (stat_v[i]),
      .pin_o    (pin_v[i]),
      .edge_req (edge_v[i]),
      .msg_req  (msgreq_v[i])
    );
  end

  tirc_msg_arb #(.NUM_TIMERS(NUM_TIMERS)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (msgreq_v),
    .msgs   (msg_v),
    .valid_q(msg_valid),
    .addr_q (msg_addr),
    .data_q (msg_data)
  );

  always_comb begin
    pulse_d   = '0;
    pin_level = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (edge_v[i] && pin_v[i] != '0)
        pulse_d   = pulse_d | (32'd1 << pin_v[i]);
      if (stat_v[i] && pin_v[i] != '0)
        pin_level = pin_level | (32'd1 << pin_v[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_pulse <= '0;
    else        pin_pulse <= pulse_d;
  end

  always_comb begin
    rd_cfg = '0;
    rd_msg = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (rd_idx == IDXW'(i)) begin
        rd_cfg = cfg_v[i];
        rd_msg = msg_v[i];
      end
    end
  end

  assign status = stat_v;

  // R5: a pulse appears only in the cycle after a fire
  a_r5_pulse_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (|pin_pulse) |-> $past(|fire));

  // R11: a level on any pin requires some timer to hold its status bit
  a_r11_level_has_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (|pin_level) |-> (|status));
endmodule

// File: tb/tirc_top_test.sv
module tirc_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NT   = 3;
  localparam int IDXW = 2;
  localparam logic [63:0] RST_CFG = 64'h00F00000_00008010;

  typedef struct packed {
    logic [63:0] wdata;
    logic [63:0] expv;
  } vec_t;

  // R2 / R3 field-merge vectors on timer 0
  localparam vec_t VECS [7] = '{
    '{64'h0000000000000000, 64'h00F0000000008010},
    '{64'hFFFFFFFFFFFFFFFF, 64'h00F00000FFFFFEDF},
    '{64'h0000000000002A06, 64'h00F000000000AA16},
    '{64'h0000000000000A04, 64'h00F0000000008014},
    '{64'h0000000000002F04, 64'h00F000000000AE14},
    '{64'h1234567800000004, 64'h00F0000000008014},
    '{64'h0000000000004A04, 64'h00F000000000CA14}
  };

  logic clk, rst_n;
  logic cfg_we, msg_we;
  logic [IDXW-1:0] cfg_idx, msg_idx, rd_idx;
  logic [63:0] cfg_wdata, msg_wdata, rd_cfg, rd_msg;
  logic [NT-1:0] stat_clr, fire, status;
  logic [31:0] pin_pulse, pin_level, msg_addr, msg_data;
  logic msg_valid;
  int nchk, nfail;
  bit done;

  tirc_top #(.NUM_TIMERS(NT), .PIN_COUNT(24)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .msg_we(msg_we), .msg_idx(msg_idx),
    .msg_wdata(msg_wdata), .stat_clr(stat_clr), .fire(fire),
    .rd_idx(rd_idx), .rd_cfg(rd_cfg), .rd_msg(rd_msg), .status(status),
    .pin_pulse(pin_pulse), .pin_level(pin_level), .msg_valid(msg_valid),
    .msg_addr(msg_addr), .msg_data(msg_data));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic wr_cfg(input int idx, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IDXW'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_msg(input int idx, input logic [63:0] d);
    @(negedge clk);
    msg_we = 1'b1; msg_idx = IDXW'(idx); msg_wdata = d;
    @(negedge clk);
    msg_we = 1'b0;
  endtask

  // drive fire for one edge; returns at the negedge after that edge
  task automatic do_fire(input logic [NT-1:0] f);
    @(negedge clk);
    fire = f;
    @(negedge clk);
    fire = '0;
  endtask

  task automatic do_clr(input logic [NT-1:0] c);
    @(negedge clk);
    stat_clr = c;
    @(negedge clk);
    stat_clr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    nchk = 0; nfail = 0; done = 0;
    rst_n = 1'b0; cfg_we = 0; msg_we = 0; cfg_idx = '0; msg_idx = '0;
    cfg_wdata = '0; msg_wdata = '0; stat_clr = '0; fire = '0; rd_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < NT; i++) begin
      rd_idx = IDXW'(i); #1;
      chk("R1 cfg", rd_cfg, RST_CFG);
      chk("R1 msg", rd_msg, 64'h0);
    end
    chk("R1 status", 64'(status), 64'h0);
    chk("R1 level", 64'(pin_level), 64'h0);
    chk("R1 pulse", 64'(pin_pulse), 64'h0);
    chk("R1 msg_valid", 64'(msg_valid), 64'h0);
    rd_idx = '0;

    // R2 / R3 vector table
    for (int v = 0; v < 7; v++) begin
      wr_cfg(0, VECS[v].wdata);
      chk("R2/R3 vector", rd_cfg, VECS[v].expv);
    end

    // R5 edge pulse on pin 20
    wr_cfg(0, 64'h2804);
    do_fire(3'b001);
    chk("R5 pulse", 64'(pin_pulse), 64'h0010_0000);
    chk("R5 no status", 64'(status), 64'h0);
    @(negedge clk);
    chk("R5 one cycle", 64'(pin_pulse), 64'h0);

    // R4 disabled, and unrouted
    wr_cfg(0, 64'h2800);
    do_fire(3'b001);
    chk("R4 disabled", 64'(pin_pulse), 64'h0);
    wr_cfg(0, 64'h0006);
    do_fire(3'b001);
    chk("R4 unrouted pulse", 64'(pin_pulse), 64'h0);
    chk("R4 unrouted status", 64'(status), 64'h0);

    // R6 level on pin 20
    wr_cfg(0, 64'h2806);
    do_fire(3'b001);
    chk("R6 status", 64'(status), 64'h1);
    chk("R6 level", 64'(pin_level), 64'h0010_0000);
    @(negedge clk);
    chk("R6 held", 64'(pin_level), 64'h0010_0000);
    do_fire(3'b001);
    chk("R6 refire no pulse", 64'(pin_pulse), 64'h0);
    chk("R6 refire status", 64'(status), 64'h1);

    // R11 shared pin, R8 clear
    wr_cfg(1, 64'h2806);
    do_fire(3'b010);
    chk("R11 both held", 64'(status), 64'h3);
    do_clr(3'b001);
    chk("R8 clear one", 64'(status), 64'h2);
    chk("R11 shared level", 64'(pin_level), 64'h0010_0000);
    do_clr(3'b010);
    chk("R8 level released", 64'(pin_level), 64'h0);

    // R9 stranding rules
    do_fire(3'b001);
    wr_cfg(0, 64'h0001_2806);
    chk("R9 keep", 64'(status), 64'h1);
    wr_cfg(0, 64'h2A06);
    chk("R9 route change", 64'(status), 64'h0);
    chk("R9 level dropped", 64'(pin_level), 64'h0);
    do_fire(3'b001);
    chk("R9 new pin", 64'(pin_level), 64'h0020_0000);
    wr_cfg(0, 64'h2A04);
    chk("R9 to edge", 64'(status), 64'h0);
    wr_cfg(0, 64'h2A06);
    do_fire(3'b001);
    wr_cfg(0, 64'h2A02);
    chk("R9 disable", 64'(status), 64'h0);
    wr_cfg(0, 64'h2A06);
    do_fire(3'b001);
    wr_cfg(0, 64'h6A06);
    chk("R9 to message", 64'(status), 64'h0);

    // R7 message delivery
    wr_msg(0, 64'hFEE00000_00000041);
    chk("R7 msg readback", rd_msg, 64'hFEE00000_00000041);
    wr_cfg(0, 64'h4004);
    do_fire(3'b001);
    chk("R7 valid", 64'(msg_valid), 64'h1);
    chk("R7 addr", 64'(msg_addr), 64'hFEE00000);
    chk("R7 data", 64'(msg_data), 64'h41);
    chk("R7 no pin", 64'(pin_pulse), 64'h0);
    @(negedge clk);
    chk("R7 one cycle", 64'(msg_valid), 64'h0);

    // R10 priority among simultaneous messages
    wr_msg(1, 64'h11111111_22222222);
    wr_msg(2, 64'h33333333_44444444);
    wr_cfg(1, 64'h4004);
    wr_cfg(2, 64'h4004);
    do_fire(3'b110);
    chk("R10 valid", 64'(msg_valid), 64'h1);
    chk("R10 addr", 64'(msg_addr), 64'h11111111);
    chk("R10 data", 64'(msg_data), 64'h22222222);
    @(negedge clk);
    chk("R10 loser dropped", 64'(msg_valid), 64'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule